// File: doc/BRIEF.md
# Line-Boundary Bus Arbiter

This block decides which of several bus masters (for example a processor core and a coprocessor) owns a shared system bus. Ownership may move only at a legal arbitration point. A legal point is either a cycle in which the bus carries no transfer, or a cycle in which a transfer to the last word of an aligned four-word line is accepted. Because of this rule, a cache line fill of four sequential 32-bit words always finishes under one owner. The memory burst of eight 16-bit halfwords behind that fill is therefore never broken up by a change of master.

At a legal point the requesting master of highest rank wins. The rank order is a parameter, and by default master 0 ranks highest. If nobody requests at a legal point, the grant parks on the default master. The block outputs a registered one-hot grant vector and the matching owner index. Data paths, address decoding and slave wait generation are handled elsewhere.

Top module: `line_bus_arbiter`

## Requirements
- R1: After synchronous active-low reset, `grant_o` is 3'b001 and `owner_o` is 0, with the bus treated as idle.
- R2: In a cycle with `xfer_valid_i` low (bus idle), the grant moves at the next rising edge to the highest-ranked requesting master.
- R3: In a cycle where `xfer_valid_i` is high but `xfer_accept_i` is low (wait-stalled), the grant and owner do not change at the next edge, whatever the requests are.
- R4: An accepted transfer whose word offset `line_word_i` (address bits [3:2]) is 0, 1 or 2 leaves the grant unchanged at the next edge, even when a higher-ranked master requests or the owner drops its request.
- R5: An accepted transfer with `line_word_i` == 2'b11 is an arbitration point, and the new owner takes effect at the next edge.
- R6: With the default order, rank is master 0 > master 1 > master 2 when several masters request at an arbitration point.
- R7: At an arbitration point with no request asserted, the grant parks on master 0.
- R8: `grant_o` has exactly one bit set at every clock edge after reset, and `owner_o` is the index of that bit.
- R9: A four-word line fill (offsets 0,1,2,3, each accepted) completes under the owner that started it. A change of owner appears only after the fourth word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 3 | Per-master bus request, bit i for master i |
| xfer_valid_i | input | 1 | A transfer is on the bus this cycle (low means idle) |
| xfer_accept_i | input | 1 | The current transfer is accepted by the slave this cycle |
| line_word_i | input | 2 | Address bits [3:2] of the current transfer (word offset in the line) |
| grant_o | output | 3 | One-hot bus grant, registered |
| owner_o | output | 2 | Index of the granted master, registered |

## Verification
Two functions can fall in the same cycle: the line-end arbitration point and a change in the request pattern. Examples are a higher-ranked master raising its request on the very cycle the last word is accepted, or the owner dropping its request mid-line while others wait. Directed tasks drive such cycles and check the grant after the following edge. The grant must switch exactly at the line end and hold on the three earlier words and on every stalled cycle. Stalled cycles that present the last-word offset without acceptance are mixed in, so that a design decoding the offset without the accept strobe is caught.

// File: rtl/lba_pkg.sv
// Package for the line-boundary arbiter.
// Holds the reason code that tells why the owner may change in a cycle.
// Assumes nothing beyond standard SystemVerilog.
package lba_pkg;

    typedef enum logic [1:0] {
        ARB_HOLD     = 2'd0,   // no arbitration this cycle
        ARB_IDLE     = 2'd1,   // bus idle, arbitration allowed
        ARB_LINE_END = 2'd2    // last word of a line accepted
    } arb_reason_e;

endpackage

// File: rtl/lba_boundary_detect.sv
// Decides whether the current cycle is a legal arbitration point.
// Assumes line_word carries the word offset inside an aligned line.
// A stalled transfer (valid without accept) never counts.
module lba_boundary_detect #(
    parameter int LINE_WORDS = 4,
    parameter int OFS_W      = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input  logic               xfer_valid,
    input  logic               xfer_accept,
    input  logic [OFS_W-1:0]   line_word,
    output logic               arb_pt,
    output lba_pkg::arb_reason_e reason
);
    import lba_pkg::*;

    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(LINE_WORDS - 1);

    logic last_word_done;

    // Purpose: flag an accepted transfer to the final word of a line.
    always_comb begin
        last_word_done = xfer_valid && xfer_accept && (line_word == LAST_OFS);
    end

    // Purpose: classify the cycle as hold, idle point or line-end point.
    always_comb begin
        if (!xfer_valid) begin
            reason = ARB_IDLE;
        end else if (last_word_done) begin
            reason = ARB_LINE_END;
        end else begin
            reason = ARB_HOLD;
        end
        arb_pt = (reason != ARB_HOLD);
    end

endmodule

// File: rtl/lba_prio_pick.sv
// Fixed-priority picker over the master requests.
// RANK_ORDER holds 8-bit fields; field k names the master at rank k,
// rank 0 winning. Assumes every master appears exactly once in the order.
module lba_prio_pick #(
    parameter int                          N_MST      = 3,
    parameter int                          IDX_W      = 2,
    parameter logic [N_MST*8-1:0]          RANK_ORDER = 24'h02_01_00
) (
    input  logic [N_MST-1:0] req,
    output logic             hit,
    output logic [IDX_W-1:0] pick
);
    logic [N_MST-1:0] rank_req;
    logic [IDX_W-1:0] rank_idx [N_MST];

    // Purpose: reorder the requests by rank, one lane per rank.
    for (genvar k = 0; k < N_MST; k++) begin : g_rank
        localparam int MST = int'(RANK_ORDER[k*8 +: 8]);
        assign rank_req[k] = req[MST];
        assign rank_idx[k] = IDX_W'(MST);
    end

    // Purpose: select the lowest-numbered rank that requests.
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = N_MST - 1; k >= 0; k--) begin
            if (rank_req[k]) begin
                hit  = 1'b1;
                pick = rank_idx[k];
            end
        end
    end

endmodule

// File: rtl/lba_owner_reg.sv
// Owner state of the arbiter: registered owner index and one-hot grant.
// Loads next_idx only when upd is high; resets to the default master.
module lba_owner_reg #(
    parameter int N_MST   = 3,
    parameter int IDX_W   = 2,
    parameter int DEF_MST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [IDX_W-1:0] next_idx,
    output logic [IDX_W-1:0] owner_q,
    output logic [N_MST-1:0] grant_q
);
    // Purpose: hold the owner index across non-arbitration cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= IDX_W'(DEF_MST);
        end else if (upd) begin
            owner_q <= next_idx;
        end
    end

    // Purpose: keep one registered grant bit per master, decoded from next_idx.
    for (genvar i = 0; i < N_MST; i++) begin : g_gnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grant_q[i] <= (i == DEF_MST);
            end else if (upd) begin
                grant_q[i] <= (next_idx == IDX_W'(i));
            end
        end
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant_q) == 1) && grant_q[owner_q]);

endmodule

// File: rtl/line_bus_arbiter.sv
// Line-boundary bus arbiter (top).
// Grants the shared bus to one master; ownership may change only when the
// bus is idle or when the last word of an aligned line is accepted, so a
// line fill stays with one owner. Fixed priority by RANK_ORDER; parks on
// DEF_MST when nobody requests. Assumes requests and bus status are
// synchronous to clk.
module line_bus_arbiter #(
    parameter int                 N_MST      = 3,
    parameter int                 LINE_WORDS = 4,
    parameter int                 DEF_MST    = 0,
    parameter int                 IDX_W      = (N_MST > 1) ? $clog2(N_MST) : 1,
    parameter int                 OFS_W      = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
    parameter logic [N_MST*8-1:0] RANK_ORDER = 24'h02_01_00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic             xfer_valid_i,
    input  logic             xfer_accept_i,
    input  logic [OFS_W-1:0] line_word_i,
    output logic [N_MST-1:0] grant_o,
    output logic [IDX_W-1:0] owner_o
);
    import lba_pkg::*;

    localparam int                 TOP_MST  = int'(RANK_ORDER[7:0]);
    localparam logic [OFS_W-1:0]   LAST_OFS = OFS_W'(LINE_WORDS - 1);

    logic             arb_pt;
    arb_reason_e      reason;
    logic             any_req;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] next_idx;

    lba_boundary_detect #(
        .LINE_WORDS (LINE_WORDS),
        .OFS_W      (OFS_W)
    ) u_bnd (
        .xfer_valid  (xfer_valid_i),
        .xfer_accept (xfer_accept_i),
        .line_word   (line_word_i),
        .arb_pt      (arb_pt),
        .reason      (reason)
    );

    lba_prio_pick #(
        .N_MST      (N_MST),
        .IDX_W      (IDX_W),
        .RANK_ORDER (RANK_ORDER)
    ) u_pick (
        .req  (req_i),
        .hit  (any_req),
        .pick (pick_idx)
    );

    // Purpose: choose the winner, or the park master when nobody requests.
    always_comb begin
        next_idx = any_req ? pick_idx : IDX_W'(DEF_MST);
    end

    lba_owner_reg #(
        .N_MST   (N_MST),
        .IDX_W   (IDX_W),
        .DEF_MST (DEF_MST)
    ) u_own (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (arb_pt),
        .next_idx (next_idx),
        .owner_q  (owner_o),
        .grant_q  (grant_o)
    );

    // R3 R4
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_i && !(xfer_accept_i && (line_word_i == LAST_OFS)))
        |=> $stable(owner_o) && $stable(grant_o));

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_valid_i && ($countones(req_i) == 1)) |=> (grant_o == $past(req_i)));

    // R6
    top_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pt && req_i[TOP_MST]) |=> grant_o[TOP_MST]);

    // R7
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pt && (req_i == '0)) |=> (owner_o == IDX_W'(DEF_MST)));

    // R5
    line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reason == ARB_LINE_END && ($countones(req_i) == 1)) |=> (grant_o == $past(req_i)));

endmodule

// File: tb/sim_line_bus_arbiter.sv
// Directed bench for line_bus_arbiter: one task per scenario.
module sim_line_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = '0;
    logic       vld = 1'b0;
    logic       acc = 1'b0;
    logic [1:0] ofs = '0;
    logic [2:0] grant;
    logic [1:0] owner;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    line_bus_arbiter u0 (
        .clk (clk), .rst_n (rst_n), .req_i (req), .xfer_valid_i (vld),
        .xfer_accept_i (acc), .line_word_i (ofs), .grant_o (grant), .owner_o (owner)
    );

    // apply inputs after a falling edge, let one rising edge pass, sample at next fall
    task automatic step(input logic [2:0] r, input logic v, input logic a, input logic [1:0] o);
        req = r; vld = v; acc = a; ofs = o;
        @(negedge clk);
    endtask

    task automatic expect_owner(input int exp, input string tag);
        logic [2:0] eg;
        eg = 3'(1 << exp);
        total++;
        if (grant !== eg || owner !== 2'(exp)) begin
            bad++;
            $display("FAIL %s: grant=%b owner=%0d expected grant=%b owner=%0d",
                     tag, grant, owner, eg, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(3'b110, 1'b1, 1'b1, 2'd3);
        step(3'b110, 1'b1, 1'b1, 2'd3);
        expect_owner(0, "R1 reset state");
        req = '0; vld = 1'b0; acc = 1'b0; ofs = '0;
        rst_n = 1'b1;
    endtask

    task automatic t_idle_priority;
        step(3'b010, 1'b0, 1'b0, 2'd0); expect_owner(1, "R2 idle single req m1");
        step(3'b100, 1'b0, 1'b0, 2'd0); expect_owner(2, "R2 idle single req m2");
        step(3'b110, 1'b0, 1'b0, 2'd0); expect_owner(1, "R6 m1 over m2");
        step(3'b111, 1'b0, 1'b0, 2'd0); expect_owner(0, "R6 m0 over all");
    endtask

    task automatic t_wait_stall;
        // owner 0; last-word offset presented but not accepted
        for (int k = 0; k < 3; k++) begin
            step(3'b010, 1'b1, 1'b0, 2'd3); expect_owner(0, "R3 stalled last word holds");
        end
        step(3'b010, 1'b1, 1'b1, 2'd3); expect_owner(1, "R5 accepted last word switches");
    endtask

    task automatic t_line_fill;
        // owner 1 runs a full line while m0 requests from the first word
        step(3'b011, 1'b1, 1'b1, 2'd0); expect_owner(1, "R4 word0 holds");
        step(3'b001, 1'b1, 1'b1, 2'd1); expect_owner(1, "R4 word1 holds, owner req dropped");
        step(3'b001, 1'b1, 1'b0, 2'd3); expect_owner(1, "R3 stall inside line");
        step(3'b001, 1'b1, 1'b1, 2'd2); expect_owner(1, "R9 word2 still same owner");
        step(3'b001, 1'b1, 1'b1, 2'd3); expect_owner(0, "R9 switch after word3");
    endtask

    task automatic t_late_request;
        // m0 owns; m2 running line, higher rank arrives on the last word
        step(3'b100, 1'b0, 1'b0, 2'd0); expect_owner(2, "R2 idle to m2");
        step(3'b100, 1'b1, 1'b1, 2'd2); expect_owner(2, "R4 word2 holds");
        step(3'b101, 1'b1, 1'b1, 2'd3); expect_owner(0, "R5 R6 same-cycle req at line end");
    endtask

    task automatic t_park;
        step(3'b010, 1'b0, 1'b0, 2'd0); expect_owner(1, "R2 idle to m1");
        step(3'b000, 1'b1, 1'b1, 2'd1); expect_owner(1, "R4 no req mid line holds");
        step(3'b000, 1'b1, 1'b1, 2'd3); expect_owner(0, "R7 park at line end");
        step(3'b100, 1'b0, 1'b0, 2'd0); expect_owner(2, "R2 idle to m2");
        step(3'b000, 1'b0, 1'b0, 2'd0); expect_owner(0, "R7 park when idle");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_priority();
        t_wait_stall();
        t_line_fill();
        t_late_request();
        t_park();
        // R8 final sanity: one-hot grant after all scenarios
        total++;
        if ($countones(grant) != 1) begin
            bad++;
            $display("FAIL R8 grant not one-hot: grant=%b expected one bit", grant);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule